// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a synchronous burst memory. It captures an external address when a burst begins, then walks the two lowest address bits through a four-beat sequence, one beat per clock on which the advance input is asserted. The upper address bits stay at the captured value for the whole burst.

Two active-low address strobes can begin a burst. The processor strobe counts only while the primary chip enable (active low) is asserted. The cache-controller strobe counts regardless of that enable. If both strobes qualify on the same edge, the processor strobe wins. Both load the same external address, so the priority has no effect at the outputs. A static mode input chooses the beat order: linear (low bits count up modulo 4) or interleaved (low bits are the start value XOR the beat number).

Control is a five-state machine.
- ST_IDLE is the state after reset. It leaves only on a load.
- ST_BEAT0, ST_BEAT1, ST_BEAT2 and ST_BEAT3 each name the current beat number.

The machine has these transitions:
- A load moves any state to ST_BEAT0.
- An advance with no load steps ST_BEATn to ST_BEATn+1, and ST_BEAT3 wraps to ST_BEAT0.
- With no load and no advance, the state holds.

The address output is derived from a base register and the beat number. A registered burst-start flag is high for the one cycle in which a newly loaded address first appears.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is applied, and after it is released until the first load, addr_out is 0 and burst_start is 0.
- R2: A rising edge with proc_stb_n=0 and ce_n=0 loads addr_in. From the next cycle addr_out equals that address and burst_start is 1.
- R3: A rising edge with proc_stb_n=0, ce_n=1 and ctl_stb_n=1 loads nothing. Both addr_out and burst_start keep their values in the next cycle, except that burst_start falls to 0.
- R4: A rising edge with ctl_stb_n=0 loads addr_in whatever the value of ce_n, and burst_start is 1 in the next cycle.
- R5: A load takes precedence over adv_n=0 on the same edge. The beat number restarts at 0, so addr_out equals addr_in exactly.
- R6: With mode_ilv=0, each edge with adv_n=0 and no load makes addr_out[1:0] equal to (start + k) mod 4, where start is the loaded low bits and k is the number of advances since the load. addr_out[15:2] stays at the loaded value.
- R7: With mode_ilv=1, the same advances give addr_out[1:0] = start XOR k (k mod 4).
- R8: An edge with no load and adv_n=1 leaves addr_out unchanged.
- R9: After the fourth advance the sequence wraps to beat 0 and continues; it does not stop.
- R10: Before the first load after reset, adv_n=0 has no effect and addr_out stays 0.
- R11: burst_start is 1 only in the cycle directly after a load edge and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | 16 | External address captured on a load |
| proc_stb_n | input | 1 | Processor address strobe, active low, qualified by ce_n |
| ctl_stb_n | input | 1 | Cache-controller address strobe, active low, unqualified |
| ce_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_ilv | input | 1 | Beat order: 0 linear, 1 interleaved; static configuration |
| addr_out | output | 16 | Current word address |
| burst_start | output | 1 | High for the cycle in which a freshly loaded address appears |

## Verification
Every input is registered on a rising edge. A load or advance seen at edge N therefore shows on addr_out and burst_start in the cycle that follows N, with no further delay. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge that samples them. It compares both outputs on the following falling edge, which is the first point at which the result of that edge is due. Reset values are compared the same way before the first load.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } seq_state_e;

    // Beat number carried by each burst state
    function automatic logic [BEAT_W-1:0] beat_of(input seq_state_e s);
        logic [BEAT_W-1:0] b;
        case (s)
            ST_BEAT1: b = 2'd1;
            ST_BEAT2: b = 2'd2;
            ST_BEAT3: b = 2'd3;
            default:  b = 2'd0;
        endcase
        return b;
    endfunction

    // Low address bits for a given start value, beat and ordering
    function automatic logic [BEAT_W-1:0] order_bits(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        logic [BEAT_W-1:0] r;
        if (ilv) r = start ^ beat;
        else     r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/bas_start_arb.sv
module bas_start_arb (
    input  logic proc_stb_n,
    input  logic ctl_stb_n,
    input  logic ce_n,
    output logic load
);
    logic proc_take;
    logic ctl_take;

    always_comb begin
        // processor strobe is qualified by chip enable and has priority
        proc_take = !proc_stb_n && !ce_n;
        ctl_take  = !ctl_stb_n && !proc_take;
        load      = proc_take || ctl_take;
    end
endmodule

// File: rtl/bas_beat_fsm.sv
module bas_beat_fsm
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat,
    output logic              active
);
    seq_state_e state_q;
    seq_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = step ? ST_BEAT1 : ST_BEAT0;
                ST_BEAT1: state_d = step ? ST_BEAT2 : ST_BEAT1;
                ST_BEAT2: state_d = step ? ST_BEAT3 : ST_BEAT2;
                ST_BEAT3: state_d = step ? ST_BEAT0 : ST_BEAT3;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        beat   = beat_of(state_q);
        active = (state_q != ST_IDLE);
    end

    AST_LOAD_TO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == ST_BEAT0)); // R5
    AST_WRAP_TO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT3 && step && !load) |=> (state_q == ST_BEAT0)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/bas_addr_gen.sv
module bas_addr_gen
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BEAT_W-1:0] beat,
    input  logic              mode_ilv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    base_q <= '0;
        else if (load) base_q <= addr_in;
    end

    generate
        if (HI_W > 0) begin : g_split
            assign addr_out = {base_q[ADDR_W-1:BEAT_W],
                               order_bits(base_q[BEAT_W-1:0], beat, mode_ilv)};
        end else begin : g_low_only
            assign addr_out = order_bits(base_q[BEAT_W-1:0], beat, mode_ilv);
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_stb_n,
    input  logic              ctl_stb_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              mode_ilv,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_start
);
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic              active;
    logic              start_q;

    bas_start_arb u_arb (
        .proc_stb_n (proc_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .ce_n       (ce_n),
        .load       (load)
    );

    bas_beat_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (!adv_n),
        .beat   (beat),
        .active (active)
    );

    bas_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .beat     (beat),
        .mode_ilv (mode_ilv),
        .addr_out (addr_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= load;
    end

    assign burst_start = start_q;

    AST_CTL_ALWAYS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stb_n |=> burst_start); // R4
    AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && ce_n && ctl_stb_n) |=> !burst_start); // R3
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(addr_out) || !$stable(mode_ilv))); // R8
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R6
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && active && !mode_ilv) |=>
        ((addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 2'd1)
         || !$stable(mode_ilv))); // R6
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_in = 16'h0;
    logic        proc_stb_n = 1'b1;
    logic        ctl_stb_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        mode_ilv = 1'b0;
    logic [15:0] addr_out;
    logic        burst_start;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int m_base = 0;
    int m_beat = 0;
    bit m_active = 1'b0;
    bit m_start = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n), .ce_n(ce_n),
        .adv_n(adv_n), .mode_ilv(mode_ilv),
        .addr_out(addr_out), .burst_start(burst_start)
    );

    function automatic int exp_addr();
        int lo;
        lo = m_base % 4;
        if (mode_ilv) lo = lo ^ m_beat;
        else          lo = (lo + m_beat) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (addr_out !== 16'(exp_addr())) begin
            errors++;
            $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, 16'(exp_addr()));
        end
        checks++;
        if (burst_start !== m_start) begin
            errors++;
            $display("FAIL %s burst_start actual=%0b expected=%0b", tag, burst_start, m_start);
        end
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit p, input bit c, input bit ce, input bit adv,
                       input logic [15:0] a, input string tag);
        proc_stb_n = p; ctl_stb_n = c; ce_n = ce; adv_n = adv; addr_in = a;
        @(posedge clk);
        if ((!p && !ce) || !c) begin
            m_base = int'(a); m_beat = 0; m_active = 1'b1; m_start = 1'b1;
        end else begin
            m_start = 1'b0;
            if (m_active && !adv) m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        // R10: advance ignored before first load
        repeat (3) cyc(1, 1, 1, 0, 16'h5555, "R10 advance idle");
        // R3: processor strobe blocked by chip enable
        cyc(0, 1, 1, 1, 16'h1234, "R3 gated proc strobe");
        // R2: processor strobe with enable
        cyc(0, 1, 0, 1, 16'hABC5, "R2 proc load");
        cyc(1, 1, 0, 1, 16'h0000, "R11 pulse ends");
        // R6/R9: linear walk with wrap
        repeat (6) cyc(1, 1, 0, 0, 16'hFFFF, "R6 R9 linear walk");
        // R8: hold
        repeat (3) cyc(1, 1, 1, 1, 16'h0F0F, "R8 hold");
        // R3 again mid-burst
        cyc(0, 1, 1, 0, 16'h4444, "R3 gated mid-burst");
        // R4: cache strobe ignores chip enable
        cyc(1, 0, 1, 1, 16'h7FFE, "R4 ctl load ce off");
        cyc(1, 1, 1, 0, 16'h0000, "R6 step after ctl");
        // R5: load beats advance
        cyc(1, 0, 1, 0, 16'h3003, "R5 ctl with advance");
        cyc(0, 0, 0, 0, 16'h9A0B, "R5 both strobes");
        cyc(1, 0, 1, 1, 16'h2222, "R11 back-to-back load");
        cyc(1, 1, 1, 1, 16'h0000, "R11 pulse ends");
        // R7: interleaved order, mode changed together with a load
        mode_ilv = 1'b1;
        cyc(1, 0, 1, 1, 16'hC001, "R7 ilv load start 1");
        repeat (5) cyc(1, 1, 1, 0, 16'h0000, "R7 R9 ilv walk");
        cyc(0, 1, 0, 1, 16'h00A2, "R7 ilv load start 2");
        repeat (4) cyc(1, 1, 0, 0, 16'h0000, "R7 ilv walk start 2");
        cyc(1, 1, 0, 1, 16'h0000, "R8 ilv hold");
        cyc(1, 0, 0, 1, 16'hFFFF, "R7 ilv load start 3");
        repeat (4) cyc(1, 1, 0, 0, 16'h0000, "R7 ilv walk start 3");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule